// File: doc/BRIEF.md
# Dual-Rate Scanline Timing Generator

This block counts the cycles of one raster scanline and turns the count into the horizontal control signals of a video chip. The signals are a one-cycle interrupt-pending pulse at the start of each line, a line-start pulse for an outside vertical counter, the blanking level, display enable, a pixel-visible level, a right-border level and horizontal sync. A single input picks between the two refresh standards. A 50 Hz line is 512 cycles long and a 60 Hz line is 508 cycles long.

The rate input is read on every clock. Each event fires only when the counter reaches the position that belongs to the rate in force at that moment. The line end uses the same rule. Switching the rate in the middle of a line can therefore step past an event that has not happened yet. The usual case is display enable staying high because its 60 Hz switch-off position has already gone by, and this removes the right border. The pixel-visible level is display enable seen through a fixed 28-cycle pipeline.

Top module: `scan_timing_gen`

## Requirements
- R1: `line_pos` counts up by one on each clock. It returns to 0 after reading 511 when `rate60`=0 and after reading 507 when `rate60`=1. At every clock the comparison uses the `rate60` value present at that clock.
- R2: `hbi_pend` and `line_start` are high for exactly the one cycle in which `line_pos` reads 0 after a wrap. They stay low otherwise, and they stay low after reset.
- R3: `hblank` goes low in the cycle in which `line_pos` reads 32, at either rate. It goes high in the cycle in which `line_pos` reads 460 (50 Hz) or 456 (60 Hz).
- R4: `de` goes high when `line_pos` reads 56 (50 Hz) or 52 (60 Hz). It goes low when `line_pos` reads 376 (50 Hz) or 372 (60 Hz).
- R5: `pix_vis` equals the value `de` had 28 cycles earlier. It therefore rises at position 84 or 80.
- R6: `rborder` goes high in the cycle in which `pix_vis` falls (position 404 or 400). It goes low in the cycle in which `hblank` is set. It is never high together with `pix_vis`.
- R7: `hsync` is high from position 468 up to but not including 508 at 50 Hz, and from 464 up to but not including 504 at 60 Hz.
- R8: A synchronous active-high `rst` sets `line_pos` to 0 and `hblank` to 1 and clears every other output and the delay pipeline.
- R9: If `rate60` goes high in a 50 Hz line for the clock that moves `line_pos` to 376, display enable is not cleared. `de` stays high and no right border appears in that line.
- R10: If `rate60` is high when `line_pos` reads 508 to 511, the next clock wraps `line_pos` to 0 and raises `line_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| rate60 | input | 1 | Live rate select: 1 = 60 Hz, 0 = 50 Hz |
| line_pos | output | 10 | Current cycle within the scanline |
| line_start | output | 1 | One-cycle pulse at each line wrap |
| hbi_pend | output | 1 | One-cycle horizontal interrupt pending pulse |
| hblank | output | 1 | Horizontal blanking level |
| de | output | 1 | Display enable level |
| pix_vis | output | 1 | Display enable delayed by the pixel latency |
| rborder | output | 1 | Right border level |
| hsync | output | 1 | Horizontal sync level |

## Verification
A wrong counter value shows up on `line_pos` at the next clock. It then shifts every later edge of the line and the line length, so a line-long compare exposes it within one scanline. A wrong level flag persists until its next compare position, and a mid-line rate switch can carry it into the following line. A stuck or misaligned delay pipeline shows as `pix_vis` and `rborder` edges 28 cycles off from `de`, which becomes visible within the same line. The rate switches at 375 and at 509 test the cases where a wrong stored state would otherwise stay hidden.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
  parameter int POS_W   = 10;
  parameter int PIX_LAT = 28;

  typedef logic [POS_W-1:0] pos_t;

  localparam pos_t LAST50   = pos_t'(511);
  localparam pos_t LAST60   = pos_t'(507);
  localparam pos_t BLANK_OFF = pos_t'(32);

  // last position of a line for the given rate
  function automatic pos_t last_pos(input logic r60);
    return r60 ? LAST60 : LAST50;
  endfunction

  function automatic pos_t de_on(input logic r60);
    return r60 ? pos_t'(52) : pos_t'(56);
  endfunction

  function automatic pos_t de_off(input logic r60);
    return r60 ? pos_t'(372) : pos_t'(376);
  endfunction

  function automatic pos_t blank_on(input logic r60);
    return r60 ? pos_t'(456) : pos_t'(460);
  endfunction

  function automatic pos_t sync_on(input logic r60);
    return r60 ? pos_t'(464) : pos_t'(468);
  endfunction

  function automatic pos_t sync_off(input logic r60);
    return r60 ? pos_t'(504) : pos_t'(508);
  endfunction
endpackage

// File: rtl/scan_pos_counter.sv
module scan_pos_counter
  import scan_timing_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rate60,
  output pos_t pos_q,
  output pos_t pos_n,
  output logic wrap_n
);
  // wrap test uses >= so a late switch to the short line still ends it
  always_comb begin
    wrap_n = (pos_q >= last_pos(rate60));
    pos_n  = wrap_n ? '0 : pos_q + pos_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= pos_n;
  end

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST50);

  // R10
  short_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (rate60 && pos_q >= LAST60) |=> (pos_q == '0));
endmodule

// File: rtl/scan_event_flags.sv
module scan_event_flags
  import scan_timing_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rate60,
  input  pos_t pos_q,
  input  pos_t pos_n,
  input  logic wrap_n,
  output logic de_q,
  output logic blank_q,
  output logic sync_q,
  output logic hbi_q,
  output logic start_q,
  output logic blank_set
);
  logic de_set, de_clr, blank_clr, sync_set, sync_clr;

  // events are judged on the position the counter moves to, with the live rate
  always_comb begin
    de_set    = (pos_n == de_on(rate60));
    de_clr    = (pos_n == de_off(rate60));
    blank_set = (pos_n == blank_on(rate60));
    blank_clr = (pos_n == BLANK_OFF);
    sync_set  = (pos_n == sync_on(rate60));
    sync_clr  = (pos_n == sync_off(rate60));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q    <= 1'b0;
      blank_q <= 1'b1;
      sync_q  <= 1'b0;
      hbi_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (de_set)         de_q <= 1'b1;
      else if (de_clr)    de_q <= 1'b0;
      if (blank_set)      blank_q <= 1'b1;
      else if (blank_clr) blank_q <= 1'b0;
      if (sync_set)       sync_q <= 1'b1;
      else if (sync_clr)  sync_q <= 1'b0;
      hbi_q   <= wrap_n;
      start_q <= wrap_n;
    end
  end

  // R2
  hbi_single_chk: assert property (@(posedge clk) disable iff (rst)
    hbi_q |=> !hbi_q);

  // R2
  hbi_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hbi_q |-> (pos_q == '0));

  // R4
  de_rise_pos_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(de_q) |-> (pos_q == de_on($past(rate60))));

  // R7
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> blank_q);
endmodule

// File: rtl/scan_pixel_delay.sv
module scan_pixel_delay #(
  parameter int LAT = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic de_q,
  input  logic blank_set,
  output logic pix_q,
  output logic border_q
);
  logic [LAT-1:0] pipe;
  logic           pix_nxt;

  assign pix_q   = pipe[LAT-1];
  assign pix_nxt = pipe[LAT-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      border_q <= 1'b0;
    end else begin
      pipe <= {pipe[LAT-2:0], de_q};
      if (blank_set)              border_q <= 1'b0;
      else if (pix_q && !pix_nxt) border_q <= 1'b1;
    end
  end

  // R6
  border_excl_chk: assert property (@(posedge clk) disable iff (rst)
    border_q |-> !pix_q);

  // R6
  border_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(border_q) |-> $fell(pix_q));
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rate60,
  output logic [POS_W-1:0] line_pos,
  output logic             line_start,
  output logic             hbi_pend,
  output logic             hblank,
  output logic             de,
  output logic             pix_vis,
  output logic             rborder,
  output logic             hsync
);
  pos_t pos_q, pos_n;
  logic wrap_n, blank_set;

  scan_pos_counter u_cnt (
    .clk(clk), .rst(rst), .rate60(rate60),
    .pos_q(pos_q), .pos_n(pos_n), .wrap_n(wrap_n)
  );

  scan_event_flags u_evt (
    .clk(clk), .rst(rst), .rate60(rate60),
    .pos_q(pos_q), .pos_n(pos_n), .wrap_n(wrap_n),
    .de_q(de), .blank_q(hblank), .sync_q(hsync),
    .hbi_q(hbi_pend), .start_q(line_start), .blank_set(blank_set)
  );

  scan_pixel_delay #(.LAT(PIX_LAT)) u_dly (
    .clk(clk), .rst(rst), .de_q(de), .blank_set(blank_set),
    .pix_q(pix_vis), .border_q(rborder)
  );

  assign line_pos = pos_q;

  // R8
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (line_pos == '0 && hblank && !de && !hsync && !hbi_pend));
endmodule

// File: tb/scan_timing_gen_test.sv
module scan_timing_gen_test;
  localparam int PER = 10;

  typedef struct {
    int pos; bit ls; bit hbi; bit hb; bit de; bit pix; bit rb; bit hs;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate60 = 1'b0;
  logic [9:0] line_pos;
  logic line_start, hbi_pend, hblank, de, pix_vis, rborder, hsync;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];
  exp_t m;
  bit dh[28];

  always #(PER/2) clk = ~clk;

  scan_timing_gen uut (
    .clk(clk), .rst(rst), .rate60(rate60), .line_pos(line_pos),
    .line_start(line_start), .hbi_pend(hbi_pend), .hblank(hblank),
    .de(de), .pix_vis(pix_vis), .rborder(rborder), .hsync(hsync)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s at pos %0d: actual %0d expected %0d", tag, m.pos, act, expv);
    end
  endtask

  // reference step written from the event table of the requirements
  task automatic model(input bit s, input bit r);
    int len, np; bit opix;
    if (r) begin
      m = '{0, 0, 0, 1, 0, 0, 0, 0};
      foreach (dh[i]) dh[i] = 0;
      return;
    end
    len = s ? 508 : 512;
    np  = (m.pos + 1 >= len) ? 0 : m.pos + 1;
    m.ls  = (np == 0);
    m.hbi = (np == 0);
    if (np == (s ? 52 : 56)) m.de = 1;
    if (np == (s ? 372 : 376)) m.de = 0;
    if (np == 32) m.hb = 0;
    if (np == (s ? 456 : 460)) m.hb = 1;
    if (np == (s ? 464 : 468)) m.hs = 1;
    if (np == (s ? 504 : 508)) m.hs = 0;
    opix  = m.pix;
    m.pix = dh[27];
    for (int i = 27; i > 0; i--) dh[i] = dh[i-1];
    dh[0] = m.de;
    if (np == (s ? 456 : 460)) m.rb = 0;
    else if (opix && !m.pix) m.rb = 1;
    m.pos = np;
  endtask

  task automatic step(input bit s, input bit r);
    @(negedge clk);
    rate60 = s;
    rst = r;
    model(s, r);
    exp_q.push_back(m);
  endtask

  task automatic settle;
    @(posedge clk);
    #(PER/4);
  endtask

  // monitor: compare each cycle against the queued expectation
  always @(posedge clk) begin
    exp_t e;
    #(PER/4);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk("R1 line_pos", int'(line_pos), e.pos);
      chk("R2 line_start", line_start, e.ls);
      chk("R2 hbi_pend", hbi_pend, e.hbi);
      chk("R3 hblank", hblank, e.hb);
      chk("R4 de", de, e.de);
      chk("R5 pix_vis", pix_vis, e.pix);
      chk("R6 rborder", rborder, e.rb);
      chk("R7 hsync", hsync, e.hs);
    end
  end

  initial begin
    #(PER*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m = '{0, 0, 0, 1, 0, 0, 0, 0};
    repeat (3) step(0, 1);
    settle();
    // R8 reset state
    chk("R8 reset pos", int'(line_pos), 0);
    chk("R8 reset hblank", hblank, 1);
    chk("R8 reset hbi", hbi_pend, 0);
    repeat (1024) step(0, 0);           // two 50 Hz lines
    repeat (1016) step(1, 0);           // two 60 Hz lines
    while (m.pos != 0) step(0, 0);
    while (m.pos != 375) step(0, 0);
    while (m.pos != 400) step(1, 0);    // switch lands on 376
    settle();
    chk("R9 de held", de, 1);
    chk("R9 no border", rborder, 0);
    repeat (700) step(1, 0);
    while (m.pos != 509) step(0, 0);
    step(1, 0);
    settle();
    chk("R10 wrap pos", int'(line_pos), 0);
    chk("R10 line_start", line_start, 1);
    while (m.pos != 300) step(1, 0);
    repeat (400) step(0, 0);            // 60 -> 50 mid-line
    step(0, 1);
    step(0, 1);
    settle();
    chk("R8 mid reset pos", int'(line_pos), 0);
    chk("R8 mid reset de", de, 0);
    chk("R8 mid reset pix", pix_vis, 0);
    repeat (600) step(0, 0);
    repeat (3) @(posedge clk);
    #(PER/2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule